// File: doc/BRIEF.md
# Branch and Call Resolution Unit

This block resolves the control-flow outcome of one jump-class instruction per cycle for a virtual machine with 64-bit registers. The issue stage presents the program counter (counted in whole instructions), the 4-bit operation code, a 2-bit source-select field, a class bit (64-bit or 32-bit compare class), both register operands and the 16-bit offset and 32-bit immediate fields. In the same cycle the unit returns the next program counter and a taken indication. It also raises a helper-call request with its flavour, a program-exit strobe, a return-stack overflow strobe and an illegal-encoding strobe.

Program-local calls push their return address onto a return stack of parameterised depth (8 by default). An exit instruction pops that stack when it holds entries and ends the program when it is empty. The stack commits on the rising clock edge of the cycle in which the instruction is presented with `instValid` high. All other outputs are combinational from the inputs and the stack state. The unit does not execute helpers and does not save or restore registers.

Top module: `branch_resolver`

## Requirements
- R1: Operation codes are 0x0 unconditional jump, 0x1 equal, 0x2 unsigned greater, 0x3 unsigned greater-or-equal, 0x4 bit test (dst AND operand nonzero), 0x5 not equal, 0x6 signed greater, 0x7 signed greater-or-equal, 0x8 call, 0x9 exit, 0xa unsigned less, 0xb unsigned less-or-equal, 0xc signed less and 0xd signed less-or-equal. A taken branch gives nextPc = pc + 1 + sign-extended displacement, modulo 2^PC_W. Every other outcome that is not a return gives pc + 1, and `taken` is low.
- R2: The unconditional jump is always taken. With `is64`=1 (64-bit class) its displacement is the 16-bit offset. With `is64`=0 (32-bit class) its displacement is the 32-bit immediate.
- R3: The equal, not-equal, bit-test and four unsigned comparisons (codes 0x1, 0x5, 0x4, 0x2, 0x3, 0xa, 0xb) take the branch by the 16-bit offset exactly when the relation holds with both values read as unsigned numbers.
- R4: The signed comparisons (codes 0x6, 0x7, 0xc, 0xd) read both values as two's complement numbers.
- R5: In the 32-bit class, conditional jumps compare only bits 31:0 of both values, and signed relations use bit 31 as the sign. The upper 32 bits have no effect.
- R6: For conditional jumps, srcSel bit 0 = 1 compares against `srcVal`. srcSel bit 0 = 0 compares against the immediate sign-extended to 64 bits, and `srcVal` is then ignored.
- R7: A call (0x8, 64-bit class) with srcSel 0 raises `helperReq` with `helperKind`=0 (helper by address). With srcSel 2 it raises `helperReq` with `helperKind`=1 (helper by identifier). In both cases `taken` is low and nextPc = pc + 1.
- R8: A call with srcSel 1 is a program-local call. It is taken, its displacement is the immediate, and it pushes pc + 1 onto the return stack.
- R9: Exit (0x9, 64-bit class) with a non-empty return stack is taken. Its nextPc is the most recently pushed address, which is then removed (last in, first out).
- R10: Exit with an empty return stack raises `progExit`, leaves `taken` low and gives nextPc = pc + 1.
- R11: A local call made while the stack holds RS_DEPTH entries raises `stackErr` and still jumps. Its return address is not stored, so the existing entries stay intact.
- R12: Exit or call in the 32-bit class, call with srcSel 3, and codes 0xe and 0xf raise `illegalOp`. They give nextPc = pc + 1 with `taken`, `helperReq` and `progExit` low, and leave the return stack unchanged.
- R13: While `instValid` is low, `taken`, `helperReq`, `progExit`, `stackErr` and `illegalOp` are low and the return stack does not change.
- R14: After reset the return stack is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| instValid | input | 1 | A jump-class instruction is presented this cycle |
| pc | input | PC_W | Program counter of the instruction, in instruction units |
| opCode | input | 4 | Operation code |
| srcSel | input | 2 | Source-select field |
| is64 | input | 1 | 1 = 64-bit jump class, 0 = 32-bit jump class |
| dstVal | input | DATA_W | Destination register value |
| srcVal | input | DATA_W | Source register value |
| offVal | input | 16 | Offset field |
| immVal | input | 32 | Immediate field |
| nextPc | output | PC_W | Resolved next program counter |
| taken | output | 1 | Control flow leaves the sequential path |
| helperReq | output | 1 | Helper call requested |
| helperKind | output | 1 | 0 = helper by address, 1 = helper by identifier |
| progExit | output | 1 | Program terminates |
| stackErr | output | 1 | Local call found the return stack full |
| illegalOp | output | 1 | Encoding is not valid for this class |

## Verification
The properties take for granted that the issue stage holds the instruction fields steady through each cycle. They also take for granted that call and exit are presented only with `instValid` high when they are meant to act on the return stack. The properties tie the strobes back to the opcode, class and source select that could legally produce them. The stimulus changes inputs only on the falling edge and samples a quarter period later. It keeps `instValid` low through reset and drives every encoding, including the reserved ones, only as whole, settled instructions. Stack tests fill the stack to its exact depth before the overflowing call, so each push and pop has a known expected address.

// File: rtl/br_pkg.sv
package br_pkg;
  localparam int OFF_W = 16;
  localparam int IMM_W = 32;
  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OP_JUMP  = 4'h0;
  localparam logic [OPC_W-1:0] OP_EQ    = 4'h1;
  localparam logic [OPC_W-1:0] OP_UGT   = 4'h2;
  localparam logic [OPC_W-1:0] OP_UGE   = 4'h3;
  localparam logic [OPC_W-1:0] OP_BTEST = 4'h4;
  localparam logic [OPC_W-1:0] OP_NE    = 4'h5;
  localparam logic [OPC_W-1:0] OP_SGT   = 4'h6;
  localparam logic [OPC_W-1:0] OP_SGE   = 4'h7;
  localparam logic [OPC_W-1:0] OP_CALL  = 4'h8;
  localparam logic [OPC_W-1:0] OP_EXIT  = 4'h9;
  localparam logic [OPC_W-1:0] OP_ULT   = 4'ha;
  localparam logic [OPC_W-1:0] OP_ULE   = 4'hb;
  localparam logic [OPC_W-1:0] OP_SLT   = 4'hc;
  localparam logic [OPC_W-1:0] OP_SLE   = 4'hd;

  typedef enum logic [2:0] {
    CK_EQ, CK_NE, CK_SET, CK_GT, CK_GE, CK_LT, CK_LE
  } cmp_kind_e;

  typedef struct packed {
    logic      condJump;
    logic      jumpAlways;
    logic      dispFromImm;
    logic      pushRet;
    logic      exitReq;
    logic      helperReq;
    logic      helperKind;
    logic      illegal;
    cmp_kind_e cmpKind;
    logic      cmpSigned;
    logic      useReg;
    logic      wide;
  } br_strobe_t;
endpackage

// File: rtl/br_control.sv
module br_control
  import br_pkg::*;
(
  input  logic             instValid,
  input  logic [OPC_W-1:0] opCode,
  input  logic [1:0]       srcSel,
  input  logic             is64,
  output br_strobe_t       strobes
);
  always_comb begin
    strobes        = '0;
    strobes.useReg = srcSel[0];
    strobes.wide   = is64;
    if (instValid) begin
      case (opCode)
        OP_JUMP: begin
          strobes.jumpAlways  = 1'b1;
          strobes.dispFromImm = !is64;
        end
        OP_EQ:    begin strobes.condJump = 1'b1; strobes.cmpKind = CK_EQ;  end
        OP_NE:    begin strobes.condJump = 1'b1; strobes.cmpKind = CK_NE;  end
        OP_BTEST: begin strobes.condJump = 1'b1; strobes.cmpKind = CK_SET; end
        OP_UGT:   begin strobes.condJump = 1'b1; strobes.cmpKind = CK_GT;  end
        OP_UGE:   begin strobes.condJump = 1'b1; strobes.cmpKind = CK_GE;  end
        OP_ULT:   begin strobes.condJump = 1'b1; strobes.cmpKind = CK_LT;  end
        OP_ULE:   begin strobes.condJump = 1'b1; strobes.cmpKind = CK_LE;  end
        OP_SGT: begin
          strobes.condJump = 1'b1; strobes.cmpKind = CK_GT; strobes.cmpSigned = 1'b1;
        end
        OP_SGE: begin
          strobes.condJump = 1'b1; strobes.cmpKind = CK_GE; strobes.cmpSigned = 1'b1;
        end
        OP_SLT: begin
          strobes.condJump = 1'b1; strobes.cmpKind = CK_LT; strobes.cmpSigned = 1'b1;
        end
        OP_SLE: begin
          strobes.condJump = 1'b1; strobes.cmpKind = CK_LE; strobes.cmpSigned = 1'b1;
        end
        OP_CALL: begin
          if (!is64) strobes.illegal = 1'b1;
          else begin
            case (srcSel)
              2'd0: begin strobes.helperReq = 1'b1; strobes.helperKind = 1'b0; end
              2'd2: begin strobes.helperReq = 1'b1; strobes.helperKind = 1'b1; end
              2'd1: begin
                strobes.pushRet     = 1'b1;
                strobes.jumpAlways  = 1'b1;
                strobes.dispFromImm = 1'b1;
              end
              default: strobes.illegal = 1'b1;
            endcase
          end
        end
        OP_EXIT: begin
          if (is64) strobes.exitReq = 1'b1;
          else      strobes.illegal = 1'b1;
        end
        default: strobes.illegal = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/br_retstack.sv
module br_retstack #(
  parameter int PC_W     = 32,
  parameter int RS_DEPTH = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            pushEn,
  input  logic [PC_W-1:0] pushVal,
  input  logic            popEn,
  output logic [PC_W-1:0] topVal,
  output logic            empty,
  output logic            full
);
  localparam int CNT_W = $clog2(RS_DEPTH + 1);
  localparam int IDX_W = (RS_DEPTH > 1) ? $clog2(RS_DEPTH) : 1;

  logic [PC_W-1:0]  slots [RS_DEPTH];
  logic [CNT_W-1:0] count;
  logic [IDX_W-1:0] topIdx;
  logic [IDX_W-1:0] wrIdx;

  assign topIdx = IDX_W'(count - 1'b1);
  assign wrIdx  = IDX_W'(count);
  assign empty  = (count == '0);
  assign full   = (count == CNT_W'(RS_DEPTH));
  assign topVal = slots[topIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                count <= '0;
    else if (pushEn && !full) count <= count + 1'b1;
    else if (popEn && !empty) count <= count - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (pushEn && !full) slots[wrIdx] <= pushVal;
  end
endmodule

// File: rtl/br_datapath.sv
module br_datapath
  import br_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int PC_W     = 32,
  parameter int RS_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  br_strobe_t        strobes,
  input  logic [PC_W-1:0]   pc,
  input  logic [DATA_W-1:0] dstVal,
  input  logic [DATA_W-1:0] srcVal,
  input  logic [OFF_W-1:0]  offVal,
  input  logic [IMM_W-1:0]  immVal,
  output logic [PC_W-1:0]   nextPc,
  output logic              taken,
  output logic              helperReq,
  output logic              helperKind,
  output logic              progExit,
  output logic              stackErr,
  output logic              illegalOp
);
  localparam int NARROW_W = DATA_W / 2;

  logic [DATA_W-1:0] rhsRaw, lhsCmp, rhsCmp;
  logic [DATA_W-1:0] lhsNarU, lhsNarS, rhsNarU, rhsNarS, immWide;
  logic              isEq, isLt, anyBit, cmpHold;
  logic [PC_W-1:0]   seqPc, disp, branchPc, topVal;
  logic              stkEmpty, stkFull, pushEn, popEn;

  // operand selection and class narrowing
  assign immWide = DATA_W'($signed(immVal));
  assign rhsRaw  = strobes.useReg ? srcVal : immWide;
  assign lhsNarU = DATA_W'(dstVal[NARROW_W-1:0]);
  assign lhsNarS = DATA_W'($signed(dstVal[NARROW_W-1:0]));
  assign rhsNarU = DATA_W'(rhsRaw[NARROW_W-1:0]);
  assign rhsNarS = DATA_W'($signed(rhsRaw[NARROW_W-1:0]));

  always_comb begin
    if (strobes.wide) begin
      lhsCmp = dstVal;
      rhsCmp = rhsRaw;
    end else if (strobes.cmpSigned) begin
      lhsCmp = lhsNarS;
      rhsCmp = rhsNarS;
    end else begin
      lhsCmp = lhsNarU;
      rhsCmp = rhsNarU;
    end
  end

  assign isEq   = (lhsCmp == rhsCmp);
  assign isLt   = strobes.cmpSigned ? ($signed(lhsCmp) < $signed(rhsCmp)) : (lhsCmp < rhsCmp);
  assign anyBit = |(lhsCmp & rhsCmp);

  always_comb begin
    case (strobes.cmpKind)
      CK_EQ:   cmpHold = isEq;
      CK_NE:   cmpHold = !isEq;
      CK_SET:  cmpHold = anyBit;
      CK_GT:   cmpHold = !isLt && !isEq;
      CK_GE:   cmpHold = !isLt;
      CK_LT:   cmpHold = isLt;
      CK_LE:   cmpHold = isLt || isEq;
      default: cmpHold = 1'b0;
    endcase
  end

  // target arithmetic
  assign seqPc    = pc + PC_W'(1);
  assign disp     = strobes.dispFromImm ? PC_W'($signed(immVal)) : PC_W'($signed(offVal));
  assign branchPc = seqPc + disp;

  // return stack control
  assign pushEn   = strobes.pushRet && !stkFull;
  assign popEn    = strobes.exitReq && !stkEmpty;
  assign stackErr = strobes.pushRet && stkFull;
  assign progExit = strobes.exitReq && stkEmpty;

  br_retstack #(.PC_W(PC_W), .RS_DEPTH(RS_DEPTH)) u_retstack (
    .clk    (clk),
    .rstN   (rstN),
    .pushEn (pushEn),
    .pushVal(seqPc),
    .popEn  (popEn),
    .topVal (topVal),
    .empty  (stkEmpty),
    .full   (stkFull)
  );

  logic branchGo;
  assign branchGo = (strobes.condJump && cmpHold) || strobes.jumpAlways;
  assign taken    = branchGo || popEn;

  always_comb begin
    if (popEn)         nextPc = topVal;
    else if (branchGo) nextPc = branchPc;
    else               nextPc = seqPc;
  end

  assign helperReq  = strobes.helperReq;
  assign helperKind = strobes.helperReq && strobes.helperKind;
  assign illegalOp  = strobes.illegal;
endmodule

// File: rtl/branch_resolver.sv
module branch_resolver
  import br_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int PC_W     = 32,
  parameter int RS_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [PC_W-1:0]   pc,
  input  logic [3:0]        opCode,
  input  logic [1:0]        srcSel,
  input  logic              is64,
  input  logic [DATA_W-1:0] dstVal,
  input  logic [DATA_W-1:0] srcVal,
  input  logic [15:0]       offVal,
  input  logic [31:0]       immVal,
  output logic [PC_W-1:0]   nextPc,
  output logic              taken,
  output logic              helperReq,
  output logic              helperKind,
  output logic              progExit,
  output logic              stackErr,
  output logic              illegalOp
);
  br_strobe_t strobes;

  br_control u_control (
    .instValid(instValid),
    .opCode   (opCode),
    .srcSel   (srcSel),
    .is64     (is64),
    .strobes  (strobes)
  );

  br_datapath #(.DATA_W(DATA_W), .PC_W(PC_W), .RS_DEPTH(RS_DEPTH)) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .pc        (pc),
    .dstVal    (dstVal),
    .srcVal    (srcVal),
    .offVal    (offVal),
    .immVal    (immVal),
    .nextPc    (nextPc),
    .taken     (taken),
    .helperReq (helperReq),
    .helperKind(helperKind),
    .progExit  (progExit),
    .stackErr  (stackErr),
    .illegalOp (illegalOp)
  );
endmodule

// File: rtl/br_checker.sv
module br_checker #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic            instValid,
  input logic [PC_W-1:0] pc,
  input logic [3:0]      opCode,
  input logic [1:0]      srcSel,
  input logic            is64,
  input logic [PC_W-1:0] nextPc,
  input logic            taken,
  input logic            helperReq,
  input logic            helperKind,
  input logic            progExit,
  input logic            stackErr,
  input logic            illegalOp
);
  // R1
  seq_when_not_taken_chk: assert property (@(posedge clk) disable iff (!rstN)
    !taken |-> nextPc == pc + PC_W'(1));

  // R13
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !instValid |-> !(taken || helperReq || progExit || stackErr || illegalOp));

  // R7
  helper_kind_chk: assert property (@(posedge clk) disable iff (!rstN)
    helperReq |-> (opCode == 4'h8 && is64 && !srcSel[0] && helperKind == srcSel[1]));

  // R10
  prog_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    progExit |-> (opCode == 4'h9 && is64 && !taken));

  // R11
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    stackErr |-> (opCode == 4'h8 && srcSel == 2'd1 && taken));

  // R12
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    illegalOp |-> !(taken || helperReq || progExit || stackErr));

  // R9
  outcome_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({taken, helperReq, progExit, illegalOp}));
endmodule

bind branch_resolver br_checker #(.PC_W(PC_W)) i_br_checker (
  .clk       (clk),
  .rstN      (rstN),
  .instValid (instValid),
  .pc        (pc),
  .opCode    (opCode),
  .srcSel    (srcSel),
  .is64      (is64),
  .nextPc    (nextPc),
  .taken     (taken),
  .helperReq (helperReq),
  .helperKind(helperKind),
  .progExit  (progExit),
  .stackErr  (stackErr),
  .illegalOp (illegalOp)
);

// File: tb/test_branch_resolver.sv
module test_branch_resolver;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 32;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instValid = 1'b0;
  logic [31:0] pc = '0;
  logic [3:0]  opCode = '0;
  logic [1:0]  srcSel = '0;
  logic        is64 = 1'b1;
  logic [63:0] dstVal = '0, srcVal = '0;
  logic [15:0] offVal = '0;
  logic [31:0] immVal = '0;
  logic [31:0] nextPc;
  logic        taken, helperReq, helperKind, progExit, stackErr, illegalOp;

  int nTests = 0;
  int nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_resolver i_branch_resolver (
    .clk(clk), .rstN(rstN), .instValid(instValid), .pc(pc), .opCode(opCode),
    .srcSel(srcSel), .is64(is64), .dstVal(dstVal), .srcVal(srcVal),
    .offVal(offVal), .immVal(immVal), .nextPc(nextPc), .taken(taken),
    .helperReq(helperReq), .helperKind(helperKind), .progExit(progExit),
    .stackErr(stackErr), .illegalOp(illegalOp)
  );

  typedef struct packed {
    logic [3:0]  op;
    logic [1:0]  ss;
    logic        w;
    logic [63:0] dst;
    logic [63:0] srcv;
    logic [15:0] off;
    logic [31:0] imm;
    logic [31:0] p;
    logic        expTaken;
    logic [31:0] expNext;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 18;
  localparam vec_t VECS [NVEC] = '{
    '{4'h0, 2'd0, 1'b1, 64'd0, 64'd0, 16'd5, 32'd1000, 32'd100, 1'b1, 32'd106, 4'd2},       // R2 offset
    '{4'h0, 2'd0, 1'b0, 64'd0, 64'd0, 16'd5, 32'hFFFF_FFFD, 32'd100, 1'b1, 32'd98, 4'd2},   // R2 immediate
    '{4'h1, 2'd1, 1'b1, 64'd7, 64'd7, 16'd10, 32'd0, 32'd100, 1'b1, 32'd111, 4'd3},         // R3 eq
    '{4'h1, 2'd0, 1'b1, 64'd7, 64'd7, 16'd10, 32'd8, 32'd100, 1'b0, 32'd101, 4'd6},         // R6 imm used
    '{4'h2, 2'd1, 1'b1, '1, 64'd1, 16'hFFFE, 32'd0, 32'd100, 1'b1, 32'd99, 4'd3},           // R3 ugt
    '{4'h6, 2'd1, 1'b1, '1, 64'd1, 16'hFFFE, 32'd0, 32'd100, 1'b0, 32'd101, 4'd4},          // R4 sgt
    '{4'hc, 2'd0, 1'b1, '1, 64'd0, 16'd4, 32'd0, 32'd100, 1'b1, 32'd105, 4'd4},             // R4 slt
    '{4'h4, 2'd1, 1'b1, 64'hF0, 64'h0F, 16'd3, 32'd0, 32'd100, 1'b0, 32'd101, 4'd3},        // R3 bit test
    '{4'h4, 2'd1, 1'b1, 64'h18, 64'h10, 16'd1, 32'd0, 32'd100, 1'b1, 32'd102, 4'd3},        // R3 bit test
    '{4'h3, 2'd1, 1'b0, 64'h1_0000_0000, 64'd1, 16'd6, 32'd0, 32'd100, 1'b0, 32'd101, 4'd5},// R5 upper ignored
    '{4'hd, 2'd1, 1'b0, 64'h8000_0000, 64'd0, 16'd3, 32'd0, 32'd100, 1'b1, 32'd104, 4'd5},  // R5 bit 31 sign
    '{4'ha, 2'd0, 1'b1, 64'd5, 64'd0, 16'd2, 32'hFFFF_FFFF, 32'd100, 1'b1, 32'd103, 4'd6},  // R6 sign-extended imm
    '{4'h5, 2'd1, 1'b1, 64'h0000_0100_0000_0000, 64'd0, 16'd0, 32'd0, 32'd100, 1'b1, 32'd101, 4'd3}, // R3 ne
    '{4'hb, 2'd1, 1'b1, 64'd3, 64'd3, 16'd7, 32'd0, 32'd100, 1'b1, 32'd108, 4'd3},          // R3 ule
    '{4'h7, 2'd1, 1'b1, 64'd0, 64'hFFFF_FFFF_FFFF_FFFB, 16'd1, 32'd0, 32'd100, 1'b1, 32'd102, 4'd4}, // R4 sge
    '{4'hd, 2'd1, 1'b1, 64'd2, 64'd1, 16'd9, 32'd0, 32'd100, 1'b0, 32'd101, 4'd4},          // R4 sle
    '{4'h0, 2'd0, 1'b1, 64'd0, 64'd0, 16'd0, 32'd0, 32'hFFFF_FFFF, 1'b1, 32'd0, 4'd1},      // R1 wrap
    '{4'h1, 2'd1, 1'b0, 64'hAAAA_0000_0000_0005, 64'd5, 16'd2, 32'd0, 32'd100, 1'b1, 32'd103, 4'd5} // R5
  };

  task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [3:0] op, input logic [1:0] ss,
                       input logic w, input logic [63:0] d, input logic [63:0] s,
                       input logic [15:0] o, input logic [31:0] im, input logic [31:0] p);
    @(negedge clk);
    instValid = v; opCode = op; srcSel = ss; is64 = w;
    dstVal = d; srcVal = s; offVal = o; immVal = im; pc = p;
    #(CLK_PERIOD/4);
  endtask

  task automatic exitOp(input logic [31:0] p);
    drive(1'b1, 4'h9, 2'd0, 1'b1, 64'd0, 64'd0, 16'd0, 32'd0, p);
  endtask

  task automatic localCall(input logic [31:0] p, input logic [31:0] im);
    drive(1'b1, 4'h8, 2'd1, 1'b1, 64'd0, 64'd0, 16'd0, im, p);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    nFail++;
    $display("FAIL watchdog expired (all requirements) actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    check("R13 taken low in reset", 64'(taken), 64'd0);
    check("R13 progExit low in reset", 64'(progExit), 64'd0);
    @(negedge clk);
    rstN = 1'b1;

    // R14: stack empty after reset, so exit ends the program
    exitOp(32'd40);
    check("R14 progExit after reset", 64'(progExit), 64'd1);
    check("R10 nextPc on program exit", 64'(nextPc), 64'd41);
    check("R10 taken low on program exit", 64'(taken), 64'd0);

    // table of conditional and unconditional jumps
    for (int i = 0; i < NVEC; i++) begin
      drive(1'b1, VECS[i].op, VECS[i].ss, VECS[i].w, VECS[i].dst, VECS[i].srcv,
            VECS[i].off, VECS[i].imm, VECS[i].p);
      check($sformatf("R%0d vector %0d taken", VECS[i].req, i), 64'(taken), 64'(VECS[i].expTaken));
      check($sformatf("R%0d vector %0d nextPc", VECS[i].req, i), 64'(nextPc), 64'(VECS[i].expNext));
    end

    // R7 helper calls
    drive(1'b1, 4'h8, 2'd0, 1'b1, 64'd0, 64'd0, 16'd0, 32'd77, 32'd50);
    check("R7 helper by address req", 64'(helperReq), 64'd1);
    check("R7 helper by address kind", 64'(helperKind), 64'd0);
    check("R7 helper nextPc", 64'(nextPc), 64'd51);
    check("R7 helper not taken", 64'(taken), 64'd0);
    drive(1'b1, 4'h8, 2'd2, 1'b1, 64'd0, 64'd0, 16'd0, 32'd77, 32'd60);
    check("R7 helper by id req", 64'(helperReq), 64'd1);
    check("R7 helper by id kind", 64'(helperKind), 64'd1);

    // R8 / R9 nested local calls and returns
    localCall(32'd10, 32'd20);
    check("R8 local call taken", 64'(taken), 64'd1);
    check("R8 local call target", 64'(nextPc), 64'd31);
    localCall(32'd31, 32'hFFFF_FFEB);
    check("R8 local call negative target", 64'(nextPc), 64'd11);
    exitOp(32'd40);
    check("R9 return to latest caller", 64'(nextPc), 64'd32);
    check("R9 return taken", 64'(taken), 64'd1);
    exitOp(32'd45);
    check("R9 return to first caller", 64'(nextPc), 64'd11);
    check("R9 no program exit on return", 64'(progExit), 64'd0);
    exitOp(32'd46);
    check("R10 stack drained", 64'(progExit), 64'd1);

    // R13 invalid cycle does not push
    drive(1'b0, 4'h8, 2'd1, 1'b1, 64'd0, 64'd0, 16'd0, 32'd5, 32'd200);
    check("R13 idle call not taken", 64'(taken), 64'd0);
    exitOp(32'd210);
    check("R13 stack unchanged by idle call", 64'(progExit), 64'd1);

    // R12 illegal encodings
    drive(1'b1, 4'h9, 2'd0, 1'b0, 64'd0, 64'd0, 16'd0, 32'd0, 32'd300);
    check("R12 exit in 32-bit class flagged", 64'(illegalOp), 64'd1);
    check("R12 exit in 32-bit class no progExit", 64'(progExit), 64'd0);
    drive(1'b1, 4'h8, 2'd3, 1'b1, 64'd0, 64'd0, 16'd0, 32'd9, 32'd310);
    check("R12 call srcSel 3 flagged", 64'(illegalOp), 64'd1);
    check("R12 call srcSel 3 no helper", 64'(helperReq), 64'd0);
    check("R12 call srcSel 3 nextPc", 64'(nextPc), 64'd311);
    drive(1'b1, 4'h8, 2'd1, 1'b0, 64'd0, 64'd0, 16'd0, 32'd9, 32'd320);
    check("R12 call in 32-bit class not taken", 64'(taken), 64'd0);
    drive(1'b1, 4'he, 2'd1, 1'b1, 64'd1, 64'd1, 16'd4, 32'd0, 32'd330);
    check("R12 code 0xe flagged", 64'(illegalOp), 64'd1);
    check("R12 code 0xe not taken", 64'(taken), 64'd0);
    exitOp(32'd340);
    check("R12 stack unchanged by illegal ops", 64'(progExit), 64'd1);

    // R11 overflow
    for (int k = 0; k < 8; k++) begin
      localCall(32'(k * 100), 32'd0);
      check($sformatf("R11 fill push %0d no error", k), 64'(stackErr), 64'd0);
    end
    localCall(32'd900, 32'd3);
    check("R11 overflow flagged", 64'(stackErr), 64'd1);
    check("R11 overflow still jumps", 64'(nextPc), 64'd904);
    for (int k = 7; k >= 0; k--) begin
      exitOp(32'd1000);
      check($sformatf("R11 pop %0d address", k), 64'(nextPc), 64'(k * 100 + 1));
    end
    exitOp(32'd1000);
    check("R11 overflowing entry not stored", 64'(progExit), 64'd1);

    @(negedge clk);
    instValid = 1'b0;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule